// File: doc/BRIEF.md
# DMA Bus Burst Planner

This block turns one DMA transfer request into a series of AHB burst commands. A request carries a byte start address, a count of 32-bit beats still to move and a flag that says whether the receive or the transmit engine owns it. The block then issues commands one at a time. Each command carries the HBURST code, the start address and the beat count of one burst. A consumer that runs the AHB address and data phases takes each command through a valid/ready handshake.

The burst shape is set by a group of configuration inputs: fixed-type mode, mixed mode, aligned-beats mode, a four-times length multiplier, a per-engine length select and two programmed length fields. The block works out the effective maximum burst for the owning engine. It then picks among SINGLE, INCR4, INCR8, INCR16 and undefined-length INCR. It cuts bursts short wherever one would reach past an alignment point or a 1 KB address boundary. The configuration is captured when a request is accepted, so the inputs may change while the bursts are still being issued.

Top module: `dma_burst_planner`

## Requirements
- R1: The length field is picked at request acceptance. When the per-engine select is set and the request belongs to the receive engine, it is the receive length field; in every other case it is the transmit length field. With the multiplier set, the effective maximum burst is four times that field. Configuration inputs that change after acceptance have no effect on the request.
- R2: A picked length field that is not 1, 2, 4, 8, 16 or 32 drives `cfg_err` high from the cycle after acceptance, and the field is then treated as 1 (four with the multiplier). `cfg_err` is low after reset and after accepting a legal field.
- R3: In fixed-type mode every command is SINGLE (code 3'b000, 1 beat), INCR4 (3'b011, 4 beats), INCR8 (3'b101, 8 beats) or INCR16 (3'b111, 16 beats). The block picks the largest of these that fits in the span still allowed.
- R4: With fixed-type and mixed modes both clear, a span of one beat is SINGLE and any longer span is one undefined-length INCR (3'b001) carrying the whole span as its count.
- R5: With mixed mode set and fixed-type mode clear, a span longer than 16 beats is one INCR. A span of 16 beats or fewer is split into pieces as in R3.
- R6: With aligned-beats and fixed-type modes both set, no burst, not even the first, runs past a multiple of the effective maximum burst counted in beat addresses.
- R7: With aligned-beats set and fixed-type mode clear, the first burst is limited only by the effective maximum, the remaining count and R8. Every later burst obeys the alignment limit of R6.
- R8: No burst runs past a 1 KB byte address boundary.
- R9: The span of a command is the smallest of the remaining beats, the effective maximum and the limits of R6 to R8. Successive commands have contiguous addresses and together cover exactly the requested beats. `cmd_last` marks the final one.
- R10: `req_ready` is high only when no request is in progress. Only one command is offered at a time, and it holds steady while `cmd_ready` is low.
- R11: A request of zero beats is accepted and produces no command; `req_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Planner idle, request taken this cycle |
| req_addr | input | ADDR_W | Byte start address of the transfer |
| req_beats | input | CNT_W | Beats to move |
| req_is_rx | input | 1 | Request belongs to the receive engine |
| cfg_fixed | input | 1 | Fixed-type burst mode |
| cfg_mixed | input | 1 | Mixed burst mode |
| cfg_aligned | input | 1 | Aligned-beats mode |
| cfg_x4 | input | 1 | Multiply the length field by four |
| cfg_split | input | 1 | Receive engine uses its own length field |
| cfg_tx_len | input | 6 | Transmit (shared) length field |
| cfg_rx_len | input | 6 | Receive length field |
| cmd_valid | output | 1 | Burst command offered |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_kind | output | 3 | HBURST code of the burst |
| cmd_addr | output | ADDR_W | Byte start address of the burst |
| cmd_beats | output | CNT_W | Beats in the burst |
| cmd_last | output | 1 | Final burst of the request |
| cfg_err | output | 1 | Accepted length field was illegal |

## Verification
The bench builds the planner with its default parameters: 32-bit addresses, 13-bit beat counts, 4-byte beats and a 1 KB boundary, which is 256 beats. With these values a 128-beat multiplied burst starting just below a boundary is cut there, and transfers of a few hundred beats cross the boundary and several alignment points in one request. Consumer stalls that follow a fixed pattern exercise the hold rule, and the configuration inputs are scrambled after every acceptance to show they are captured.

// File: rtl/dmab_pkg.sv
package dmab_pkg;
  localparam int PBL_W = 6;

  typedef enum logic [2:0] {
    HB_SINGLE = 3'b000,
    HB_INCR   = 3'b001,
    HB_INCR4  = 3'b011,
    HB_INCR8  = 3'b101,
    HB_INCR16 = 3'b111
  } hburst_e;

  typedef struct packed {
    logic             fixed;
    logic             mixed;
    logic             aligned;
    logic             x4;
    logic             split;
    logic [PBL_W-1:0] tx_len;
    logic [PBL_W-1:0] rx_len;
  } burst_cfg_t;
endpackage

// File: rtl/dmab_len_sel.sv
module dmab_len_sel
  import dmab_pkg::*;
#(
  parameter int EFF_W = PBL_W + 3
) (
  input  logic             split,
  input  logic             x4,
  input  logic             is_rx,
  input  logic [PBL_W-1:0] tx_len,
  input  logic [PBL_W-1:0] rx_len,
  output logic [EFF_W-1:0] eff_len,
  output logic             len_bad
);
  // Power of two, non-zero, no larger than 32.
  function automatic logic len_legal(input logic [PBL_W-1:0] v);
    return (v != '0) && ((v & (v - 1'b1)) == '0) && (v <= PBL_W'(32));
  endfunction

  logic [PBL_W-1:0] picked;
  logic [PBL_W-1:0] base;

  always_comb begin
    picked  = (split && is_rx) ? rx_len : tx_len;
    len_bad = !len_legal(picked);
    base    = len_bad ? PBL_W'(1) : picked;
    eff_len = x4 ? (EFF_W'(base) << 2) : EFF_W'(base);
  end
endmodule

// File: rtl/dmab_shape.sv
module dmab_shape
  import dmab_pkg::*;
#(
  parameter int CNT_W   = 13,
  parameter int EFF_W   = 9,
  parameter int BND_LOG = 8
) (
  input  logic [CNT_W-1:0] beat_idx,
  input  logic [CNT_W-1:0] rem,
  input  logic [EFF_W-1:0] eff,
  input  logic             fixed,
  input  logic             mixed,
  input  logic             align_on,
  output logic [CNT_W-1:0] span,
  output logic [CNT_W-1:0] beats,
  output hburst_e          kind
);
  localparam int BND_BEATS = 1 << BND_LOG;

  function automatic logic [CNT_W-1:0] min_c(input logic [CNT_W-1:0] a,
                                             input logic [CNT_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [CNT_W-1:0] fixed_piece(input logic [CNT_W-1:0] n);
    if (n >= CNT_W'(16))      return CNT_W'(16);
    else if (n >= CNT_W'(8))  return CNT_W'(8);
    else if (n >= CNT_W'(4))  return CNT_W'(4);
    else                      return CNT_W'(1);
  endfunction

  function automatic hburst_e fixed_kind(input logic [CNT_W-1:0] n);
    case (n)
      CNT_W'(16): return HB_INCR16;
      CNT_W'(8):  return HB_INCR8;
      CNT_W'(4):  return HB_INCR4;
      default:    return HB_SINGLE;
    endcase
  endfunction

  logic [CNT_W-1:0] eff_c;
  logic [CNT_W-1:0] to_bnd;
  logic [CNT_W-1:0] al_lim;
  logic             use_fixed;

  assign eff_c  = CNT_W'(eff);
  assign to_bnd = CNT_W'(BND_BEATS) - CNT_W'(beat_idx[BND_LOG-1:0]);
  assign al_lim = eff_c - (beat_idx & (eff_c - 1'b1));

  always_comb begin
    span = min_c(min_c(rem, eff_c), to_bnd);
    if (align_on) span = min_c(span, al_lim);
    use_fixed = fixed || (mixed && (span <= CNT_W'(16)));
    if (use_fixed) begin
      beats = fixed_piece(span);
      kind  = fixed_kind(beats);
    end else begin
      beats = span;
      kind  = (span == CNT_W'(1)) ? HB_SINGLE : HB_INCR;
    end
  end
endmodule

// File: rtl/dma_burst_planner.sv
module dma_burst_planner
  import dmab_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 13,
  parameter int BEAT_BYTES = 4,
  parameter int BOUNDARY   = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_beats,
  input  logic              req_is_rx,
  input  logic              cfg_fixed,
  input  logic              cfg_mixed,
  input  logic              cfg_aligned,
  input  logic              cfg_x4,
  input  logic              cfg_split,
  input  logic [5:0]        cfg_tx_len,
  input  logic [5:0]        cfg_rx_len,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [CNT_W-1:0]  cmd_beats,
  output logic              cmd_last,
  output logic              cfg_err
);
  localparam int BEAT_SH = $clog2(BEAT_BYTES);
  localparam int BND_SH  = $clog2(BOUNDARY);
  localparam int BND_LOG = BND_SH - BEAT_SH;
  localparam int EFF_W   = PBL_W + 3;

  burst_cfg_t        cfg_q;
  logic              is_rx_q;
  logic              busy;
  logic              first;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cur_rem;

  // Named internal events
  logic              accept_fire;
  logic              issue_fire;
  logic              align_on;
  logic              final_burst;
  logic [EFF_W-1:0]  eff_len;
  logic              len_bad;
  logic [CNT_W-1:0]  beat_idx;
  logic [CNT_W-1:0]  shp_span;
  logic [CNT_W-1:0]  shp_beats;
  hburst_e           shp_kind;

  assign accept_fire = req_valid && req_ready;
  assign issue_fire  = cmd_valid && cmd_ready;
  assign align_on    = cfg_q.aligned && (cfg_q.fixed || !first);
  assign beat_idx    = CNT_W'(cur_addr >> BEAT_SH);
  assign final_burst = (cur_rem == shp_beats);

  dmab_len_sel #(.EFF_W(EFF_W)) u_len (
    .split   (cfg_q.split),
    .x4      (cfg_q.x4),
    .is_rx   (is_rx_q),
    .tx_len  (cfg_q.tx_len),
    .rx_len  (cfg_q.rx_len),
    .eff_len (eff_len),
    .len_bad (len_bad)
  );

  dmab_shape #(.CNT_W(CNT_W), .EFF_W(EFF_W), .BND_LOG(BND_LOG)) u_shape (
    .beat_idx (beat_idx),
    .rem      (cur_rem),
    .eff      (eff_len),
    .fixed    (cfg_q.fixed),
    .mixed    (cfg_q.mixed),
    .align_on (align_on),
    .span     (shp_span),
    .beats    (shp_beats),
    .kind     (shp_kind)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '{fixed: 1'b0, mixed: 1'b0, aligned: 1'b0, x4: 1'b0, split: 1'b0,
                    tx_len: PBL_W'(1), rx_len: PBL_W'(1)};
      is_rx_q  <= 1'b0;
      busy     <= 1'b0;
      first    <= 1'b0;
      cur_addr <= '0;
      cur_rem  <= '0;
    end else if (accept_fire) begin
      cfg_q    <= '{fixed: cfg_fixed, mixed: cfg_mixed, aligned: cfg_aligned, x4: cfg_x4,
                    split: cfg_split, tx_len: cfg_tx_len, rx_len: cfg_rx_len};
      is_rx_q  <= req_is_rx;
      busy     <= (req_beats != '0);
      first    <= 1'b1;
      cur_addr <= req_addr;
      cur_rem  <= req_beats;
    end else if (issue_fire) begin
      cur_addr <= cur_addr + (ADDR_W'(shp_beats) << BEAT_SH);
      cur_rem  <= cur_rem - shp_beats;
      first    <= 1'b0;
      if (final_burst) busy <= 1'b0;
    end
  end

  assign req_ready = !busy;
  assign cmd_valid = busy;
  assign cmd_kind  = shp_kind;
  assign cmd_addr  = cur_addr;
  assign cmd_beats = shp_beats;
  assign cmd_last  = final_burst;
  assign cfg_err   = len_bad;
endmodule

// File: rtl/dmab_chk.sv
module dmab_chk
  import dmab_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 13,
  parameter int BEAT_BYTES = 4,
  parameter int BOUNDARY   = 1024,
  parameter int EFF_W      = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_kind,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [CNT_W-1:0]  cmd_beats,
  input logic              cmd_last,
  input logic              fixed_q,
  input logic [EFF_W-1:0]  eff_len,
  input logic [CNT_W-1:0]  cur_rem
);
  localparam int BND_SH = $clog2(BOUNDARY);

  // R8
  bnd_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (int'(cmd_addr[BND_SH-1:0]) + int'(cmd_beats) * BEAT_BYTES) <= BOUNDARY);

  // R3
  fixed_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && fixed_q) |-> (cmd_kind != HB_INCR));

  // R3
  kind_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (((cmd_kind == HB_SINGLE) == (cmd_beats == CNT_W'(1))) &&
                   ((cmd_kind != HB_INCR4)  || (cmd_beats == CNT_W'(4))) &&
                   ((cmd_kind != HB_INCR8)  || (cmd_beats == CNT_W'(8))) &&
                   ((cmd_kind != HB_INCR16) || (cmd_beats == CNT_W'(16)))));

  // R9
  span_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_beats != '0) && (cmd_beats <= cur_rem) &&
                  (cmd_beats <= CNT_W'(eff_len)));

  // R9
  contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_last) |=>
      cmd_valid && (cmd_addr == $past(cmd_addr) + ADDR_W'(int'($past(cmd_beats)) * BEAT_BYTES)));

  // R9
  last_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_last) |=> !cmd_valid);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=>
      cmd_valid && $stable(cmd_addr) && $stable(cmd_beats) && $stable(cmd_kind));

  // R10
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && cmd_valid));
endmodule

bind dma_burst_planner dmab_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES),
  .BOUNDARY(BOUNDARY), .EFF_W(EFF_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_kind  (cmd_kind),
  .cmd_addr  (cmd_addr),
  .cmd_beats (cmd_beats),
  .cmd_last  (cmd_last),
  .fixed_q   (cfg_q.fixed),
  .eff_len   (eff_len),
  .cur_rem   (cur_rem)
);

// File: tb/tb_dma_burst_planner.sv
`timescale 1ns/1ps
module tb_dma_burst_planner;
  localparam int AW = 32;
  localparam int CW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_beats = '0;
  logic req_is_rx = 1'b0;
  logic cfg_fixed = 1'b0, cfg_mixed = 1'b0, cfg_aligned = 1'b0, cfg_x4 = 1'b0, cfg_split = 1'b0;
  logic [5:0] cfg_tx_len = 6'd1, cfg_rx_len = 6'd1;
  logic cmd_valid;
  logic cmd_ready = 1'b1;
  logic [2:0] cmd_kind;
  logic [AW-1:0] cmd_addr;
  logic [CW-1:0] cmd_beats;
  logic cmd_last;
  logic cfg_err;

  always #4 clk = ~clk;

  dma_burst_planner dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_beats(req_beats), .req_is_rx(req_is_rx),
    .cfg_fixed(cfg_fixed), .cfg_mixed(cfg_mixed), .cfg_aligned(cfg_aligned),
    .cfg_x4(cfg_x4), .cfg_split(cfg_split), .cfg_tx_len(cfg_tx_len), .cfg_rx_len(cfg_rx_len),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .cmd_beats(cmd_beats), .cmd_last(cmd_last), .cfg_err(cfg_err)
  );

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [CW-1:0] beats;
    logic [2:0]    kind;
    logic          last;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    stall_en = 1'b0;
  int    cyc = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // Reference planner written as a plain loop over integers.
  task automatic plan(input int addr, input int beats, input bit rx, input string tag);
    int sel, base, eff, a, r, n, b, k, lim;
    bit first, legal;
    sel   = (cfg_split && rx) ? int'(cfg_rx_len) : int'(cfg_tx_len);
    legal = (sel == 1) || (sel == 2) || (sel == 4) || (sel == 8) || (sel == 16) || (sel == 32);
    base  = legal ? sel : 1;
    eff   = cfg_x4 ? base * 4 : base;
    a = addr; r = beats; first = 1'b1;
    while (r > 0) begin
      n = (r < eff) ? r : eff;
      lim = (1024 - (a % 1024)) / 4;
      if (n > lim) n = lim;
      if (cfg_aligned && (cfg_fixed || !first)) begin
        lim = eff - ((a / 4) % eff);
        if (n > lim) n = lim;
      end
      if (cfg_fixed || (cfg_mixed && n <= 16)) begin
        if (n >= 16)     begin b = 16; k = 7; end
        else if (n >= 8) begin b = 8;  k = 5; end
        else if (n >= 4) begin b = 4;  k = 3; end
        else             begin b = 1;  k = 0; end
      end else begin
        b = n; k = (n == 1) ? 0 : 1;
      end
      exp_q.push_back('{addr: AW'(a), beats: CW'(b), kind: 3'(k), last: (r == b)});
      tag_q.push_back(tag);
      a += b * 4; r -= b; first = 1'b0;
    end
  endtask

  // Monitor: sets the consumer ready for the coming edge, then scores the handshake.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      cmd_ready = stall_en ? ((cyc % 3) != 1) : 1'b1;
      if (cmd_valid && cmd_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected command addr", longint'(cmd_addr), -1);
        end else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(cmd_addr == e.addr, t, "addr", longint'(cmd_addr), longint'(e.addr));
          check(cmd_beats == e.beats, t, "beats", longint'(cmd_beats), longint'(e.beats));
          check(cmd_kind == e.kind, t, "kind", longint'(cmd_kind), longint'(e.kind));
          check(cmd_last == e.last, t, "last", longint'(cmd_last), longint'(e.last));
        end
      end
    end
  end

  task automatic send(input bit fx, input bit mx, input bit al, input bit x4, input bit sp,
                      input int txl, input int rxl, input bit rx, input int addr,
                      input int beats, input string tag);
    bit exp_err;
    int sel;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_fixed = fx; cfg_mixed = mx; cfg_aligned = al; cfg_x4 = x4; cfg_split = sp;
    cfg_tx_len = 6'(txl); cfg_rx_len = 6'(rxl);
    req_addr = AW'(addr); req_beats = CW'(beats); req_is_rx = rx;
    plan(addr, beats, rx, tag);
    sel = (sp && rx) ? rxl : txl;
    exp_err = !((sel == 1) || (sel == 2) || (sel == 4) || (sel == 8) || (sel == 16) || (sel == 32));
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // R1: captured at acceptance, so scrambling the inputs now changes nothing
    cfg_fixed = ~fx; cfg_mixed = ~mx; cfg_aligned = ~al; cfg_x4 = ~x4; cfg_split = ~sp;
    cfg_tx_len = 6'd3; cfg_rx_len = 6'd0; req_is_rx = ~rx;
    check(cfg_err == exp_err, "R2", "cfg_err", longint'(cfg_err), longint'(exp_err));
    if (beats == 0) begin
      check(req_ready && !cmd_valid, "R11", "idle after zero-beat request",
            longint'({req_ready, cmd_valid}), 2);
    end else begin
      check(!req_ready, "R10", "req_ready while busy", longint'(req_ready), 0);
    end
    while (exp_q.size() != 0 || cmd_valid) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && !cmd_valid && !cfg_err, "R10", "reset state",
          longint'({req_ready, cmd_valid, cfg_err}), 4);
    rst_n = 1'b1;
    // fx mx al x4 sp txl rxl rx addr beats
    send(0, 0, 0, 0, 0, 8,  1,  0, 'h100, 20,  "R4");
    send(0, 0, 0, 0, 0, 1,  1,  0, 'h200, 3,   "R4");
    send(1, 0, 0, 1, 0, 16, 1,  0, 'h000, 70,  "R3");
    send(0, 1, 0, 0, 0, 32, 1,  0, 'h040, 45,  "R5");
    send(0, 1, 0, 1, 0, 4,  1,  1, 'h080, 31,  "R5");
    send(1, 0, 1, 0, 0, 8,  1,  0, 'h00C, 20,  "R6");
    send(0, 0, 1, 0, 0, 8,  1,  0, 'h00C, 30,  "R7");
    send(0, 0, 0, 0, 1, 16, 4,  1, 'h400, 13,  "R1");
    send(0, 0, 0, 0, 1, 16, 4,  0, 'h400, 40,  "R1");
    send(0, 0, 0, 1, 0, 2,  32, 1, 'h010, 19,  "R1");
    send(0, 0, 0, 0, 0, 3,  1,  0, 'h300, 5,   "R2");
    send(0, 0, 0, 1, 1, 16, 0,  1, 'h300, 9,   "R2");
    send(0, 0, 0, 0, 1, 48, 8,  0, 'h600, 4,   "R2");
    stall_en = 1'b1;
    send(0, 0, 0, 1, 0, 32, 1,  0, 'h3F0, 200, "R8");
    send(1, 0, 1, 1, 0, 32, 1,  0, 'h7E4, 300, "R8");
    send(0, 1, 1, 1, 1, 8,  16, 1, 'hBF4, 150, "R9");
    send(0, 0, 0, 0, 0, 8,  1,  0, 'h100, 0,   "R11");
    stall_en = 1'b0;
    repeat (3) @(negedge clk);
    check(req_ready && !cmd_valid, "R11", "idle at end",
          longint'({req_ready, cmd_valid}), 2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R10 watchdog expired: actual %0d expected %0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule